// File: doc/BRIEF.md
# Serial Receive Holding Queue with Flow Control

This block sits between the receive shift register of one asynchronous serial channel and the CPU. Each completed character arrives with its framing, parity and break indications. The block keeps the character in a small first-in first-out queue and shows the CPU the character at the head of the queue, its status bits, a ready flag and a full flag. A CPU read strobe removes the head entry.

Three mode bits, all loaded together by a mode-write strobe, shape the behaviour. The first lets the block pull the request-to-send line low by itself when a new start bit appears and the queue has no free slot. The second picks ready or full as the receive interrupt source. The third switches the status bits between showing the current head character only and showing an OR over every character that has reached the head since the last reset-error command. A sticky overrun flag records characters that were lost because the queue was full.

Top module: `rx_hold_fifo`

## Requirements
- R1: After reset the queue is empty, rxReady, fifoFull, overrun, rxIrq and all three status outputs are 0, all mode bits are 0, and rtsOut equals swRts.
- R2: rxReady is 1 whenever at least one character is held and fifoFull is 1 when all DEPTH (default 3) slots are held. Characters leave in arrival order, rxData shows the head while rxReady is 1, a cpuRead pops the head, and a cpuRead on an empty queue has no effect.
- R3: A charDone in a cycle that starts with the queue full discards the character, even if cpuRead is also high in that cycle, and sets overrun. overrun stays set until a resetErr cycle without such a discard. A discard and resetErr in the same cycle leave overrun at 1.
- R4: With modeBlockErr = 0, statFrame, statParity and statBreak are the flags of the current head character, or 0 when the queue is empty.
- R5: With modeBlockErr = 1, each status output is the OR of that flag over every character that became head since the last resetErr. resetErr clears the sum. A character that becomes head in the same cycle as resetErr is still included.
- R6: With modeAutoRts = 1, a startBit in a cycle that starts with the queue full drives rtsOut to 0 from the next cycle, while swRts stays 1. rtsOut returns to swRts as soon as the queue is no longer full.
- R7: With modeAutoRts = 0, rtsOut equals swRts at all times and startBit has no effect on it.
- R8: rxIrq equals rxReady when modeIrqFull = 0 and equals fifoFull when modeIrqFull = 1.
- R9: A modeWr cycle loads modeAutoRts, modeIrqFull and modeBlockErr together, and the new modes act from the following cycle.
- R10: charDone and cpuRead in the same cycle on a queue that is neither empty nor full both take effect: the count stays the same and the new character joins the tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startBit | input | 1 | One-cycle strobe: the shifter saw a valid start bit |
| charDone | input | 1 | One-cycle strobe: a character is complete |
| charData | input | DATA_W | Received character |
| charFrame | input | 1 | Framing error flag of the character |
| charParity | input | 1 | Parity error flag of the character |
| charBreak | input | 1 | Received break flag of the character |
| cpuRead | input | 1 | One-cycle strobe: pop the head character |
| resetErr | input | 1 | One-cycle strobe: clear overrun and the accumulated status |
| modeWr | input | 1 | Load the three mode bits |
| modeAutoRts | input | 1 | Mode value: automatic request-to-send control |
| modeIrqFull | input | 1 | Mode value: interrupt on full instead of ready |
| modeBlockErr | input | 1 | Mode value: accumulated status instead of per-character status |
| swRts | input | 1 | Software request-to-send bit, 1 = assert |
| rxData | output | DATA_W | Head character |
| statFrame | output | 1 | Framing status |
| statParity | output | 1 | Parity status |
| statBreak | output | 1 | Break status |
| overrun | output | 1 | Sticky overrun flag |
| rxReady | output | 1 | At least one character held |
| fifoFull | output | 1 | All slots held |
| rxIrq | output | 1 | Selected receive interrupt source |
| rtsOut | output | 1 | Request-to-send, 1 = asserted |

## Verification
The bench targets a character arriving in the same cycle as a read while the queue is full. A design that let the read free the slot first would keep the character and miss the overrun. It also covers the same-cycle push and pop on a partly filled queue: an error there shows up as a wrong count or a lost tail character. It checks that a block-mode sum cleared in the same cycle a new head arrives still holds that head's flags. If the design got this wrong, the flag would be lost. It also runs start bits against a full queue in auto mode. A design that cleared the software bit, or reasserted only after a later start bit, would keep rtsOut low after a read had freed a slot.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef struct packed {
    logic brk;
    logic par;
    logic frm;
  } rxqFlags_t;

  typedef struct packed {
    logic push;
    logic pop;
    logic headNew;
    logic headNext;
    logic accClr;
  } rxqStrobe_t;
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int DEPTH = 3,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rstN,
  input  logic startBit,
  input  logic charDone,
  input  logic cpuRead,
  input  logic resetErr,
  input  logic modeWr,
  input  logic modeAutoRts,
  input  logic modeIrqFull,
  input  logic modeBlockErr,
  input  logic swRts,
  output rxq_pkg::rxqStrobe_t stb,
  output logic [PW-1:0] wrPtr,
  output logic [PW-1:0] rdPtr,
  output logic [PW-1:0] nxtPtr,
  output logic blockMode,
  output logic rxReady,
  output logic fifoFull,
  output logic overrun,
  output logic rxIrq,
  output logic rtsOut
);
  logic [CW-1:0] count;
  logic autoRtsQ, irqFullQ, blockQ;
  logic rtsDrop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign fifoFull = (count == CW'(DEPTH));
  assign rxReady  = (count != '0);
  assign nxtPtr   = bump(rdPtr);
  assign blockMode = blockQ;

  always_comb begin
    stb.push     = charDone && !fifoFull;
    stb.pop      = cpuRead && rxReady;
    stb.headNew  = stb.push && ((count == '0) || (stb.pop && count == CW'(1)));
    stb.headNext = stb.pop && (count >= CW'(2));
    stb.accClr   = resetErr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      count <= count + CW'(stb.push) - CW'(stb.pop);
      if (stb.push) wrPtr <= bump(wrPtr);
      if (stb.pop)  rdPtr <= bump(rdPtr);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      autoRtsQ <= 1'b0;
      irqFullQ <= 1'b0;
      blockQ   <= 1'b0;
    end else if (modeWr) begin
      autoRtsQ <= modeAutoRts;
      irqFullQ <= modeIrqFull;
      blockQ   <= modeBlockErr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overrun <= 1'b0;
      rtsDrop <= 1'b0;
    end else begin
      if (charDone && fifoFull) overrun <= 1'b1;
      else if (resetErr)        overrun <= 1'b0;
      if (autoRtsQ && startBit && fifoFull) rtsDrop <= 1'b1;
      else if (!fifoFull)                   rtsDrop <= 1'b0;
    end
  end

  assign rxIrq  = irqFullQ ? fifoFull : rxReady;
  assign rtsOut = swRts && !(autoRtsQ && rtsDrop && fifoFull);
endmodule

// File: rtl/rxq_data.sv
module rxq_data #(
  parameter int DATA_W = 8,
  parameter int DEPTH = 3,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic clk,
  input  logic rstN,
  input  rxq_pkg::rxqStrobe_t stb,
  input  logic [PW-1:0] wrPtr,
  input  logic [PW-1:0] rdPtr,
  input  logic [PW-1:0] nxtPtr,
  input  logic blockMode,
  input  logic rxReady,
  input  logic [DATA_W-1:0] inData,
  input  rxq_pkg::rxqFlags_t inFlags,
  output logic [DATA_W-1:0] headData,
  output rxq_pkg::rxqFlags_t statFlags
);
  logic [DATA_W-1:0] dataMem [DEPTH];
  rxq_pkg::rxqFlags_t flagMem [DEPTH];
  rxq_pkg::rxqFlags_t accQ, arrive;

  for (genvar i = 0; i < DEPTH; i++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dataMem[i] <= '0;
        flagMem[i] <= '0;
      end else if (stb.push && wrPtr == PW'(i)) begin
        dataMem[i] <= inData;
        flagMem[i] <= inFlags;
      end
    end
  end

  always_comb begin
    if (stb.headNext)     arrive = flagMem[nxtPtr];
    else if (stb.headNew) arrive = inFlags;
    else                  arrive = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) accQ <= '0;
    else       accQ <= (stb.accClr ? '0 : accQ) | arrive;
  end

  assign headData  = dataMem[rdPtr];
  assign statFlags = blockMode ? accQ : (rxReady ? flagMem[rdPtr] : '0);
endmodule

// File: rtl/rx_hold_fifo.sv
module rx_hold_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic startBit,
  input  logic charDone,
  input  logic [DATA_W-1:0] charData,
  input  logic charFrame,
  input  logic charParity,
  input  logic charBreak,
  input  logic cpuRead,
  input  logic resetErr,
  input  logic modeWr,
  input  logic modeAutoRts,
  input  logic modeIrqFull,
  input  logic modeBlockErr,
  input  logic swRts,
  output logic [DATA_W-1:0] rxData,
  output logic statFrame,
  output logic statParity,
  output logic statBreak,
  output logic overrun,
  output logic rxReady,
  output logic fifoFull,
  output logic rxIrq,
  output logic rtsOut
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  rxq_pkg::rxqStrobe_t stb;
  rxq_pkg::rxqFlags_t inFlags, statFlags;
  logic [PW-1:0] wrPtr, rdPtr, nxtPtr;
  logic blockMode;

  assign inFlags = '{brk: charBreak, par: charParity, frm: charFrame};

  rxq_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .startBit(startBit), .charDone(charDone),
    .cpuRead(cpuRead), .resetErr(resetErr), .modeWr(modeWr),
    .modeAutoRts(modeAutoRts), .modeIrqFull(modeIrqFull),
    .modeBlockErr(modeBlockErr), .swRts(swRts), .stb(stb),
    .wrPtr(wrPtr), .rdPtr(rdPtr), .nxtPtr(nxtPtr), .blockMode(blockMode),
    .rxReady(rxReady), .fifoFull(fifoFull), .overrun(overrun),
    .rxIrq(rxIrq), .rtsOut(rtsOut)
  );

  rxq_data #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .nxtPtr(nxtPtr), .blockMode(blockMode), .rxReady(rxReady),
    .inData(charData), .inFlags(inFlags), .headData(rxData),
    .statFlags(statFlags)
  );

  assign statFrame  = statFlags.frm;
  assign statParity = statFlags.par;
  assign statBreak  = statFlags.brk;
endmodule

// File: rtl/rx_hold_fifo_chk.sv
module rx_hold_fifo_chk (
  input logic clk,
  input logic rstN,
  input logic startBit,
  input logic charDone,
  input logic cpuRead,
  input logic resetErr,
  input logic modeWr,
  input logic modeAutoRts,
  input logic modeIrqFull,
  input logic swRts,
  input logic overrun,
  input logic rxReady,
  input logic fifoFull,
  input logic rxIrq,
  input logic rtsOut
);
  logic autoShadow, irqShadow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      autoShadow <= 1'b0;
      irqShadow  <= 1'b0;
    end else if (modeWr) begin
      autoShadow <= modeAutoRts;
      irqShadow  <= modeIrqFull;
    end
  end

  assert_full_implies_ready_R2: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull |-> rxReady);

  assert_full_read_frees_R2: assert property (@(posedge clk) disable iff (!rstN)
    (fifoFull && cpuRead && !charDone) |=> !fifoFull);

  assert_overrun_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    (charDone && fifoFull) |=> overrun);

  assert_overrun_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    (resetErr && !charDone) |=> !overrun);

  assert_auto_drop_R6: assert property (@(posedge clk) disable iff (!rstN)
    (autoShadow && !modeWr && startBit && fifoFull && !cpuRead) |=> !rtsOut);

  assert_rts_follows_R7: assert property (@(posedge clk) disable iff (!rstN)
    !autoShadow |-> (rtsOut == swRts));

  assert_irq_full_R8: assert property (@(posedge clk) disable iff (!rstN)
    irqShadow |-> (rxIrq == fifoFull));

  assert_irq_ready_R8: assert property (@(posedge clk) disable iff (!rstN)
    !irqShadow |-> (rxIrq == rxReady));
endmodule

bind rx_hold_fifo rx_hold_fifo_chk uChk (
  .clk(clk), .rstN(rstN), .startBit(startBit), .charDone(charDone),
  .cpuRead(cpuRead), .resetErr(resetErr), .modeWr(modeWr),
  .modeAutoRts(modeAutoRts), .modeIrqFull(modeIrqFull), .swRts(swRts),
  .overrun(overrun), .rxReady(rxReady), .fifoFull(fifoFull),
  .rxIrq(rxIrq), .rtsOut(rtsOut)
);

// File: tb/rx_hold_fifo_test.sv
`timescale 1ns/1ps
module rx_hold_fifo_test;
  localparam int D = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startBit = 0, charDone = 0, cpuRead = 0, resetErr = 0, modeWr = 0;
  logic charFrame = 0, charParity = 0, charBreak = 0;
  logic modeAutoRts = 0, modeIrqFull = 0, modeBlockErr = 0, swRts = 1;
  logic [7:0] charData = '0;
  logic [7:0] rxData;
  logic statFrame, statParity, statBreak, overrun, rxReady, fifoFull, rxIrq, rtsOut;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [7:0] qd [D];
  logic [2:0] qf [D];
  int cnt = 0;
  logic [2:0] accM = '0;
  logic ovrM = 0, dropM = 0, mAuto = 0, mIrq = 0, mBlk = 0;
  bit lastModeWr = 0, lastPushPop = 0;

  always #2 clk = ~clk;

  rx_hold_fifo uut (.*);

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] expStat();
    if (mBlk) return accM;
    return (cnt > 0) ? qf[0] : 3'b000;
  endfunction

  function automatic logic expRts();
    return swRts && !(mAuto && dropM && cnt == D);
  endfunction

  task automatic checkAll();
    check("R2", "rxReady", rxReady, cnt > 0);
    check("R2", "fifoFull", fifoFull, cnt == D);
    if (cnt > 0) check(lastPushPop ? "R10" : "R2", "rxData", rxData, qd[0]);
    check(mBlk ? "R5" : "R4", "status", {statBreak, statParity, statFrame}, expStat());
    check("R3", "overrun", overrun, ovrM);
    check(mAuto ? "R6" : "R7", "rtsOut", rtsOut, expRts());
    check(lastModeWr ? "R9" : "R8", "rxIrq", rxIrq, mIrq ? (cnt == D) : (cnt > 0));
  endtask

  task automatic modelStep();
    bit full = (cnt == D);
    bit pop = cpuRead && cnt > 0;
    bit push = charDone && !full;
    logic [2:0] nf = {charBreak, charParity, charFrame};
    logic [2:0] arr = '0;
    if (mAuto && startBit && full) dropM = 1;
    else if (!full) dropM = 0;
    if (charDone && full) ovrM = 1;
    else if (resetErr) ovrM = 0;
    if (pop && cnt >= 2) arr = qf[1];
    else if (push && (cnt == 0 || (pop && cnt == 1))) arr = nf;
    accM = (resetErr ? 3'b000 : accM) | arr;
    if (pop) begin
      for (int i = 0; i < D - 1; i++) begin qd[i] = qd[i+1]; qf[i] = qf[i+1]; end
      cnt--;
    end
    if (push) begin qd[cnt] = charData; qf[cnt] = nf; cnt++; end
    lastPushPop = pop && push;
    lastModeWr = modeWr;
    if (modeWr) begin mAuto = modeAutoRts; mIrq = modeIrqFull; mBlk = modeBlockErr; end
  endtask

  task automatic drive(input bit sb, input bit cd, input bit rd, input bit re,
                       input logic [7:0] dat, input logic [2:0] fl);
    startBit = sb; charDone = cd; cpuRead = rd; resetErr = re;
    charData = dat; {charBreak, charParity, charFrame} = fl;
    modeWr = 0;
  endtask

  task automatic cycle();
    modelStep();
    @(negedge clk);
    checkAll();
  endtask

  task automatic setMode(input bit a, input bit i, input bit b);
    drive(0, 0, 0, 0, 8'h00, 3'b000);
    modeWr = 1; modeAutoRts = a; modeIrqFull = i; modeBlockErr = b;
    cycle();
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < D; i++) begin qd[i] = '0; qf[i] = '0; end
    repeat (3) @(negedge clk);
    check("R1", "reset rxReady", rxReady, 0);
    check("R1", "reset fifoFull", fifoFull, 0);
    check("R1", "reset overrun", overrun, 0);
    check("R1", "reset status", {statBreak, statParity, statFrame}, 0);
    check("R1", "reset rxIrq", rxIrq, 0);
    check("R1", "reset rtsOut", rtsOut, 1);
    rstN = 1;
    @(negedge clk);
    checkAll();

    // R10: push and pop together on a partly filled queue
    drive(0, 1, 0, 0, 8'h11, 3'b001); cycle();
    drive(0, 1, 1, 0, 8'h22, 3'b010); cycle();
    check("R10", "count after push+pop", {fifoFull, rxReady}, 2'b01);
    // R3: fill, then char with read in the same cycle while full
    drive(0, 1, 0, 0, 8'h33, 3'b000); cycle();
    drive(0, 1, 0, 0, 8'h44, 3'b100); cycle();
    drive(0, 1, 1, 0, 8'h55, 3'b111); cycle();
    check("R3", "discard with read", overrun, 1);
    // R6: auto RTS
    setMode(1, 1, 1);
    drive(0, 1, 0, 0, 8'h66, 3'b000); cycle();
    drive(1, 0, 0, 0, 8'h00, 3'b000); cycle();
    check("R6", "rts dropped while full", rtsOut, 0);
    drive(0, 0, 1, 0, 8'h00, 3'b000); cycle();
    check("R6", "rts back after read", rtsOut, 1);
    // R5: clear in the same cycle a new head arrives
    drive(0, 0, 1, 1, 8'h00, 3'b000); cycle();
    drive(0, 0, 0, 0, 8'h00, 3'b000); cycle();
    // R2: read on empty has no effect
    drive(0, 0, 1, 0, 8'h00, 3'b000); cycle();
    drive(0, 0, 1, 0, 8'h00, 3'b000); cycle();
    check("R2", "empty after reads", rxReady, 0);

    for (int n = 0; n < 4000; n++) begin
      drive(($urandom % 10) < 3, ($urandom % 10) < 4, ($urandom % 10) < 3,
            ($urandom % 20) == 0, 8'($urandom), 3'($urandom));
      if (($urandom % 40) == 0) begin
        modeWr = 1; modeAutoRts = 1'($urandom); modeIrqFull = 1'($urandom);
        modeBlockErr = 1'($urandom);
      end
      if (($urandom % 20) == 0) swRts = ~swRts;
      cycle();
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule